// File: doc/BRIEF.md
# Dual-Slope Conversion Sequencer

This block is the digital controller of an integrating ADC. It repeats one conversion cycle of constant length. Each cycle has three phases: an integrate phase of fixed length, a deintegrate phase that ends when the comparator trips, and an auto-zero phase. Auto-zero takes whatever part of the cycle the deintegrate phase did not use. The block drives one switch enable per phase and a reference-sign select. It counts deintegrate time in packed BCD digits, and it keeps the result in a display register together with its sign and an overrange flag. The integrator, the reference and the comparator are analog parts outside the block.

All cycle timing is in counts, and one count is two input clocks. The range input selects the short integrate period, which scales the reading down by ten. At the end of each cycle the block pulses a low-active strobe. At that same edge it may load the display register. The hold input stops the load. In peak mode only a larger magnitude is loaded. The underrange flag is derived from the held reading.

Top module: `dual_slope_seq`

## Requirements
- R1: All phase timing advances on one internal count every two clocks, so every phase enable stays constant for at least two clocks after it changes.
- R2: Exactly one of `az_en_o`, `int_en_o`, `deint_en_o` is high at all times. The phases run integrate, then deintegrate, then auto-zero, then integrate again. After reset the integrate phase is active.
- R3: Integrate lasts `INT_FULL` counts (2·`INT_FULL` clocks). It lasts `INT_LOW` counts instead when `range_i` was high at the clock edge that started the cycle. After reset the first cycle uses `INT_FULL`.
- R4: `sign_i` is latched at the edge that ends integrate (1 = negative input). Throughout deintegrate, `ref_neg_o` is the inverse of that latched value, and it is low in every other phase. The latched value appears on `neg_o` when the result is loaded.
- R5: `cmp_i` passes through a two-flop synchronizer. Deintegrate ends on the first count at which the synchronized comparator is high, and it lasts at most `DEINT_MAX` counts. The reading is the number of deintegrate counts minus one. It is held as packed BCD, with digit i in bits [4i+3:4i].
- R6: A whole cycle is `CYCLE_LEN` counts (2·`CYCLE_LEN` clocks) whatever the deintegrate length, because auto-zero lasts `CYCLE_LEN` − integrate − deintegrate counts.
- R7: A result is overrange, shown by `ovr_o`, if the reading is greater than `MAX_READ` or if no comparator crossing occurred within `DEINT_MAX` counts.
- R8: `udr_o` is high exactly when the displayed result is not overrange and its reading is at most `UR_LEVEL`.
- R9: `eoc_no` goes low for one clock at the end of every cycle, on the edge where auto-zero hands over to integrate. The display register changes only on that edge.
- R10: If `hold_i` is high at the end-of-cycle edge, the display register keeps its value. Conversions continue regardless.
- R11: If `peak_i` is high (and hold is low) at the end-of-cycle edge, the result is loaded only if its magnitude is greater than the held one. An overrange result ranks above any reading, and a held overrange is never replaced.
- R12: During reset the outputs are: integrate enabled, `eoc_no` high, display digits zero, `neg_o` low, `ovr_o` low, and `udr_o` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmp_i | input | 1 | Comparator, high once the integrator has crossed zero |
| sign_i | input | 1 | Integrator polarity, high for negative input |
| range_i | input | 1 | Selects the short integrate period |
| hold_i | input | 1 | Freezes the display register |
| peak_i | input | 1 | Loads only larger magnitudes |
| az_en_o | output | 1 | Auto-zero switch enable |
| int_en_o | output | 1 | Signal-integrate switch enable |
| deint_en_o | output | 1 | Reference-deintegrate switch enable |
| ref_neg_o | output | 1 | Applies the reference with negative sign |
| eoc_no | output | 1 | End-of-conversion strobe, active low |
| digits_o | output | 4·DIGITS | Displayed reading, packed BCD |
| neg_o | output | 1 | Displayed sign |
| ovr_o | output | 1 | Displayed result is overrange |
| udr_o | output | 1 | Displayed reading at or below the underrange level |

## Verification
The bench sweeps every reading from zero through the overrange boundary and also runs a deintegrate with no crossing at all. It counts clocks in each phase, so an off-by-one in the synchronizer latency or in the deintegrate stop would appear as wrong digits or a wrong phase length. A design that keeps auto-zero at a fixed length would fail the constant cycle-length check. A design that latches the range input in mid-cycle would fail the integrate-length check. The peak and hold sequences load a smaller value, a larger value and an overrange. A design that compares signed values or ignores overrange rank would load the wrong value. Readings just above and at the underrange level check the threshold comparison.

// File: rtl/dsc_pkg.sv
package dsc_pkg;

  typedef enum logic [1:0] {
    PH_INT   = 2'd0,
    PH_DEINT = 2'd1,
    PH_AZ    = 2'd2
  } phase_e;

  // packed BCD of a non-negative value, 16 digits
  function automatic logic [63:0] bcd_of(input int unsigned v);
    logic [63:0] r;
    int unsigned x;
    r = '0;
    x = v;
    for (int i = 0; i < 16; i++) begin
      r[4*i +: 4] = 4'(x % 10);
      x = x / 10;
    end
    return r;
  endfunction

endpackage

// File: rtl/dsc_tick_gen.sv
module dsc_tick_gen (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  logic div_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) div_q <= 1'b0;
    else         div_q <= ~div_q;
  end

  assign tick_o = div_q;
endmodule

// File: rtl/dsc_sync.sv
module dsc_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-2:0], d_i};
  end

  assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/dsc_bcd_counter.sv
module dsc_bcd_counter #(
  parameter int unsigned DIGITS = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  clr_i,
  input  logic                  inc_i,
  output logic [4*DIGITS-1:0]   count_o
);
  logic [DIGITS:0] carry;

  assign carry[0] = inc_i;

  for (genvar g = 0; g < DIGITS; g++) begin : g_digit
    logic [3:0] dig_q;
    logic       at_nine;

    assign at_nine      = (dig_q == 4'd9);
    assign carry[g+1]   = carry[g] & at_nine;
    assign count_o[4*g +: 4] = dig_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       dig_q <= 4'd0;
      else if (clr_i)    dig_q <= 4'd0;
      else if (carry[g]) dig_q <= at_nine ? 4'd0 : dig_q + 4'd1;
    end
  end

  logic unused_carry;
  assign unused_carry = carry[DIGITS];
endmodule

// File: rtl/dsc_display_reg.sv
module dsc_display_reg
  import dsc_pkg::*;
#(
  parameter int unsigned DIGITS   = 4,
  parameter int unsigned UR_LEVEL = 380
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                load_i,
  input  logic                hold_i,
  input  logic                peak_i,
  input  logic [4*DIGITS-1:0] res_bcd_i,
  input  logic                res_neg_i,
  input  logic                res_ovr_i,
  output logic [4*DIGITS-1:0] digits_o,
  output logic                neg_o,
  output logic                ovr_o,
  output logic                udr_o
);
  localparam int unsigned BW      = 4 * DIGITS;
  localparam logic [63:0] UR_FULL = bcd_of(UR_LEVEL);
  localparam logic [BW-1:0] UR_BCD = UR_FULL[BW-1:0];

  logic [BW-1:0] bcd_q;
  logic          neg_q;
  logic          ovr_q;
  logic          bigger;
  logic          take;

  // packed BCD orders like binary; overrange ranks above all readings
  assign bigger = {res_ovr_i, res_bcd_i} > {ovr_q, bcd_q};
  assign take   = load_i & ~hold_i & (~peak_i | bigger);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bcd_q <= '0;
      neg_q <= 1'b0;
      ovr_q <= 1'b0;
    end else if (take) begin
      bcd_q <= res_bcd_i;
      neg_q <= res_neg_i;
      ovr_q <= res_ovr_i;
    end
  end

  assign digits_o = bcd_q;
  assign neg_o    = neg_q;
  assign ovr_o    = ovr_q;
  assign udr_o    = ~ovr_q & (bcd_q <= UR_BCD);
endmodule

// File: rtl/dual_slope_seq.sv
module dual_slope_seq
  import dsc_pkg::*;
#(
  parameter int unsigned DIGITS    = 4,
  parameter int unsigned INT_FULL  = 2000,
  parameter int unsigned INT_LOW   = 200,
  parameter int unsigned DEINT_MAX = 4001,
  parameter int unsigned CYCLE_LEN = 8000,
  parameter int unsigned MAX_READ  = 3999,
  parameter int unsigned UR_LEVEL  = 380
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cmp_i,
  input  logic                sign_i,
  input  logic                range_i,
  input  logic                hold_i,
  input  logic                peak_i,
  output logic                az_en_o,
  output logic                int_en_o,
  output logic                deint_en_o,
  output logic                ref_neg_o,
  output logic                eoc_no,
  output logic [4*DIGITS-1:0] digits_o,
  output logic                neg_o,
  output logic                ovr_o,
  output logic                udr_o
);
  localparam int unsigned BW     = 4 * DIGITS;
  localparam int unsigned TOT_W  = $clog2(CYCLE_LEN);
  localparam int unsigned DCNT_W = $clog2(DEINT_MAX);
  localparam logic [TOT_W-1:0]  TOT_LAST  = TOT_W'(CYCLE_LEN - 1);
  localparam logic [TOT_W-1:0]  FULL_LAST = TOT_W'(INT_FULL - 1);
  localparam logic [TOT_W-1:0]  LOW_LAST  = TOT_W'(INT_LOW - 1);
  localparam logic [DCNT_W-1:0] DCNT_LAST = DCNT_W'(DEINT_MAX - 1);

  logic             tick;
  logic             cmp_s;
  phase_e           phase_q;
  logic [TOT_W-1:0] tot_q;
  logic [DCNT_W-1:0] dcnt_q;
  logic             range_q;
  logic             pol_q;
  logic             res_ovr_q;
  logic [BW-1:0]    res_bcd_q;
  logic [BW-1:0]    bcd_cnt;
  logic             eoc_nq;

  logic int_end, deint_hit, deint_tmo, cyc_end, bcd_clr, bcd_inc;

  dsc_tick_gen u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_o (tick)
  );

  dsc_sync #(.STAGES(2)) u_cmp_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (cmp_i),
    .q_o    (cmp_s)
  );

  assign int_end   = tick & (phase_q == PH_INT) &
                     (tot_q == (range_q ? LOW_LAST : FULL_LAST));
  assign deint_hit = tick & (phase_q == PH_DEINT) & cmp_s;
  assign deint_tmo = tick & (phase_q == PH_DEINT) & ~cmp_s & (dcnt_q == DCNT_LAST);
  assign cyc_end   = tick & (phase_q == PH_AZ) & (tot_q == TOT_LAST);
  assign bcd_clr   = int_end;
  assign bcd_inc   = tick & (phase_q == PH_DEINT) & ~cmp_s & (dcnt_q != DCNT_LAST);

  dsc_bcd_counter #(.DIGITS(DIGITS)) u_bcd (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (bcd_clr),
    .inc_i   (bcd_inc),
    .count_o (bcd_cnt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q   <= PH_INT;
      tot_q     <= '0;
      dcnt_q    <= '0;
      range_q   <= 1'b0;
      pol_q     <= 1'b0;
      res_ovr_q <= 1'b0;
      res_bcd_q <= '0;
      eoc_nq    <= 1'b1;
    end else begin
      eoc_nq <= ~cyc_end;
      if (tick) tot_q <= (tot_q == TOT_LAST) ? '0 : tot_q + 1'b1;
      if (int_end) begin
        phase_q <= PH_DEINT;
        pol_q   <= sign_i;
        dcnt_q  <= '0;
      end
      if (deint_hit) begin
        phase_q   <= PH_AZ;
        res_bcd_q <= bcd_cnt;
        res_ovr_q <= (32'(dcnt_q) > MAX_READ);
      end else if (deint_tmo) begin
        phase_q   <= PH_AZ;
        res_bcd_q <= bcd_cnt;
        res_ovr_q <= 1'b1;
      end else if (bcd_inc) begin
        dcnt_q <= dcnt_q + 1'b1;
      end
      if (cyc_end) begin
        phase_q <= PH_INT;
        range_q <= range_i;
      end
    end
  end

  dsc_display_reg #(.DIGITS(DIGITS), .UR_LEVEL(UR_LEVEL)) u_disp (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (cyc_end),
    .hold_i    (hold_i),
    .peak_i    (peak_i),
    .res_bcd_i (res_bcd_q),
    .res_neg_i (pol_q),
    .res_ovr_i (res_ovr_q),
    .digits_o  (digits_o),
    .neg_o     (neg_o),
    .ovr_o     (ovr_o),
    .udr_o     (udr_o)
  );

  assign az_en_o    = (phase_q == PH_AZ);
  assign int_en_o   = (phase_q == PH_INT);
  assign deint_en_o = (phase_q == PH_DEINT);
  assign ref_neg_o  = (phase_q == PH_DEINT) & ~pol_q;
  assign eoc_no     = eoc_nq;
endmodule

// File: rtl/dual_slope_seq_chk.sv
module dual_slope_seq_chk #(
  parameter int unsigned DIGITS    = 4,
  parameter int unsigned DEINT_MAX = 4001
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                hold_i,
  input logic                peak_i,
  input logic                az_en_o,
  input logic                int_en_o,
  input logic                deint_en_o,
  input logic                ref_neg_o,
  input logic                eoc_no,
  input logic [4*DIGITS-1:0] digits_o,
  input logic                neg_o,
  input logic                ovr_o,
  input logic                udr_o
);
  int unsigned de_clks;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         de_clks <= 0;
    else if (deint_en_o) de_clks <= de_clks + 1;
    else                 de_clks <= 0;
  end

  assert_one_phase_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({az_en_o, int_en_o, deint_en_o}) == 1);

  assert_order_deint_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(deint_en_o) |-> $past(int_en_o));

  assert_order_az_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(az_en_o) |-> $past(deint_en_o));

  assert_order_int_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(int_en_o) |-> $past(az_en_o));

  assert_two_clk_count_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable({az_en_o, int_en_o, deint_en_o}) |=> $stable({az_en_o, int_en_o, deint_en_o}));

  assert_ref_only_deint_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_neg_o |-> deint_en_o);

  assert_ref_steady_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    deint_en_o && $past(deint_en_o) |-> $stable(ref_neg_o));

  assert_deint_bound_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    de_clks <= 2 * DEINT_MAX);

  assert_flags_exclusive_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ovr_o && udr_o));

  assert_eoc_handover_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !eoc_no |-> int_en_o && $past(az_en_o));

  assert_eoc_single_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !eoc_no |=> eoc_no);

  assert_disp_on_eoc_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable({digits_o, neg_o, ovr_o}) |-> !eoc_no);

  assert_hold_freeze_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !eoc_no && $past(hold_i) |-> $stable({digits_o, neg_o, ovr_o}));

  assert_peak_mono_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !eoc_no && $past(peak_i) && !$past(hold_i) |-> {ovr_o, digits_o} >= $past({ovr_o, digits_o}));
endmodule

bind dual_slope_seq dual_slope_seq_chk #(.DIGITS(DIGITS), .DEINT_MAX(DEINT_MAX)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .hold_i     (hold_i),
  .peak_i     (peak_i),
  .az_en_o    (az_en_o),
  .int_en_o   (int_en_o),
  .deint_en_o (deint_en_o),
  .ref_neg_o  (ref_neg_o),
  .eoc_no     (eoc_no),
  .digits_o   (digits_o),
  .neg_o      (neg_o),
  .ovr_o      (ovr_o),
  .udr_o      (udr_o)
);

// File: tb/tb_dual_slope_seq.sv
`timescale 1ns/1ps
module tb_dual_slope_seq;
  localparam int DIG  = 2;
  localparam int INTF = 20;
  localparam int INTL = 2;
  localparam int DMAX = 41;
  localparam int CYC  = 80;
  localparam int MAXR = 39;
  localparam int URL  = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmp_i = 1'b0, sign_i = 1'b0, range_i = 1'b0, hold_i = 1'b0, peak_i = 1'b0;
  logic az_en, int_en, deint_en, ref_neg, eoc_n, neg, ovr, udr;
  logic [4*DIG-1:0] digits;

  int n_chk = 0;
  int n_fail = 0;
  bit cur_range = 1'b0;
  int exp_val = 0;
  bit exp_ovr = 1'b0;
  bit exp_neg = 1'b0;

  always #2.5 clk = ~clk;

  dual_slope_seq #(
    .DIGITS(DIG), .INT_FULL(INTF), .INT_LOW(INTL), .DEINT_MAX(DMAX),
    .CYCLE_LEN(CYC), .MAX_READ(MAXR), .UR_LEVEL(URL)
  ) dut (
    .clk_i(clk), .rst_ni(rst_n), .cmp_i(cmp_i), .sign_i(sign_i),
    .range_i(range_i), .hold_i(hold_i), .peak_i(peak_i),
    .az_en_o(az_en), .int_en_o(int_en), .deint_en_o(deint_en),
    .ref_neg_o(ref_neg), .eoc_no(eoc_n), .digits_o(digits),
    .neg_o(neg), .ovr_o(ovr), .udr_o(udr)
  );

  function automatic int to_bcd(input int v);
    int r = 0;
    int x = v;
    for (int i = 0; i < DIG; i++) begin
      r = r + ((x % 10) << (4 * i));
      x = x / 10;
    end
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  // one cycle; entered at a negedge inside integrate
  task automatic run_cycle(input int r, input bit nocross, input bit sgn,
                           input bit hld, input bit pk, input bit nrange);
    int n_int = 0;
    int n_de = 0;
    int n_az = 0;
    int len_exp;
    int new_val;
    bit new_ovr;
    bit take;
    sign_i = sgn;
    cmp_i  = (!nocross && r == 0);
    while (int_en) begin n_int++; @(negedge clk); end
    len_exp = cur_range ? INTL : INTF;
    chk(n_int == 2 * len_exp, "R3 integrate clocks", n_int, 2 * len_exp);
    chk(deint_en == 1'b1, "R2 deintegrate follows integrate", deint_en, 1);
    chk(ref_neg == !sgn, "R4 reference sign", ref_neg, !sgn);
    while (deint_en) begin
      if (!nocross && r > 0 && n_de == 2 * (r - 1)) cmp_i = 1'b1;
      n_de++;
      @(negedge clk);
    end
    len_exp = nocross ? DMAX : r + 1;
    chk(n_de == 2 * len_exp, "R5 deintegrate clocks", n_de, 2 * len_exp);
    chk(az_en == 1'b1, "R2 auto-zero follows deintegrate", az_en, 1);
    cmp_i   = 1'b0;
    hold_i  = hld;
    peak_i  = pk;
    range_i = nrange;
    while (eoc_n) begin n_az++; @(negedge clk); end
    chk(n_int + n_de + n_az == 2 * CYC, "R6 cycle clocks", n_int + n_de + n_az, 2 * CYC);
    chk(int_en == 1'b1, "R9 strobe at integrate start", int_en, 1);
    new_val = nocross ? DMAX - 1 : r;
    new_ovr = nocross || (r > MAXR);
    take = !hld && (!pk || (new_ovr * 1000 + new_val > exp_ovr * 1000 + exp_val));
    if (take) begin
      exp_val = new_val;
      exp_ovr = new_ovr;
      exp_neg = sgn;
    end
    chk(digits == to_bcd(exp_val), hld ? "R10 held digits" : (pk ? "R11 peak digits" : "R5 reading digits"),
        digits, to_bcd(exp_val));
    chk(ovr == exp_ovr, "R7 overrange", ovr, exp_ovr);
    chk(neg == exp_neg, "R4 displayed sign", neg, exp_neg);
    chk(udr == (!exp_ovr && exp_val <= URL), "R8 underrange", udr, (!exp_ovr && exp_val <= URL));
    cur_range = nrange;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL R9 watchdog: no progress, actual 0 expected 1");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12 reset state
    chk(int_en == 1'b1, "R12 integrate at reset", int_en, 1);
    chk(eoc_n == 1'b1, "R12 strobe idle", eoc_n, 1);
    chk(digits == '0, "R12 digits zero", digits, 0);
    chk(ovr == 1'b0 && neg == 1'b0, "R12 flags clear", {ovr, neg}, 0);
    chk(udr == 1'b1, "R12 underrange at zero", udr, 1);
    rst_n = 1'b1;
    // R5 R3 sweep of every reading through the overrange edge
    for (int r = 0; r <= DMAX - 1; r++) begin
      run_cycle(r, 1'b0, r[0], 1'b0, 1'b0, (r % 3) == 0);
    end
    // R7 no crossing at all
    run_cycle(0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    // R8 boundary of underrange
    run_cycle(URL + 1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    run_cycle(URL, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1);
    // R10 hold
    run_cycle(7, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    run_cycle(15, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
    run_cycle(30, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
    // R11 peak
    run_cycle(10, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0);
    run_cycle(5, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    run_cycle(10, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    run_cycle(25, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
    run_cycle(0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0);
    run_cycle(3, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    run_cycle(40, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    run_cycle(2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    summary();
    $finish;
  end
endmodule